// File: doc/BRIEF.md
# Up-Down Counter PWM Pair with Per-Event Action Qualifiers

This block generates two pulse-width-modulated outputs, A and B, from one triangle-shaped timebase. A counter climbs from zero to a programmed period and falls back to zero. At each clock it flags which events are present: counter at zero, counter at period, and a match against each of the two compare values, split by count direction. For each output, a separate set of two-bit action fields decides whether that event drives the output low or high, toggles it, or leaves it alone. Setting an output on the rising match and clearing it on the falling match gives a pulse centred on the period peak.

The period, both compare values and a per-output force selection are written through a small register port into staging copies. The staging copies are transferred into the live copies only when the counter sits at zero, so a half-written update never alters a cycle already in progress. The force selection holds an output low or high until it is released. A one-clock event pulse marks every arrival at the period value; it can start a conversion or raise an interrupt.

Top module: `pwm_updown_aq`

## Requirements
- R1: Counter sequence. With live period P > 0, `cnt_o` runs 0, 1, …, P, P-1, …, 1, 0 and repeats, one step per clock, for a cycle length of 2P clocks. `dir_up_o` is 1 from 0 up to and including P, and 0 from P-1 down to 0. Leaving zero always starts an upward run.
- R2: With a staged period of 0 when the counter is at zero, the counter stays at 0 and no period pulse is produced.
- R3: The live period and compare values take the staged values only on a clock where `cnt_o` is 0. Writes at other times do not change the running waveform until then.
- R4: Action code per event field: 0 keep, 1 drive low, 2 drive high, 3 toggle. An output reflects the events seen in one counter cycle on the next clock.
- R5: With compare C < P, setting an output on the rising compare match and clearing it on the falling match keeps the output high for 2·(P−C) clocks of every 2P.
- R6: Register port, written when `wr_en` is 1: address 0 period, 1 compare A, 2 compare B, 3 actions of output A, 4 actions of output B, 5 force. Action word fields: [1:0] zero, [3:2] period, [5:4] compare-A rising, [7:6] compare-A falling, [9:8] compare-B rising, [11:10] compare-B falling. Force word: [1:0] output A, [3:2] output B. A match at the period value counts as rising, and a match at zero counts as falling once counting has started.
- R7: When events coincide, a non-zero field wins in this order, from highest: compare B, compare A, period, zero. A field holding 0 does not block a lower one.
- R8: Force code 1 holds the output low, code 2 holds it high, and codes 0 and 3 leave it to the actions. A new force code is picked up at a zero event and is visible on the next clock. A released output carries on from its forced level.
- R9: `evt_prd_o` is high for exactly one clock, the clock after `cnt_o` equals a non-zero live period.
- R10: During reset, `cnt_o` is 0, `dir_up_o` is 1, and both outputs and `evt_prd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select |
| wr_data | input | DATA_W | Write value |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| evt_prd_o | output | 1 | One-clock pulse after the counter reaches the period |
| cnt_o | output | CNT_W | Current counter value |
| dir_up_o | output | 1 | 1 while counting up |

## Verification
The outputs and the period pulse are registered, so each one is due on the clock after `cnt_o` shows the causing event. Staged values and force codes move into the live copies on the clock edge that ends a zero cycle. A behavioural model advances on every rising edge from the same inputs, applying loads before writes. The bench compares the counter, direction, both outputs and the pulse against that model on every falling edge. Directed checks add the duty count, the period-pulse count, the forced levels on the clock after zero, the permanent low under compare-B priority, and the frozen counter.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int ACT_W = 12;
  localparam int NCH   = 2;
  localparam int A_PRD   = 0;
  localparam int A_CMPA  = 1;
  localparam int A_CMPB  = 2;
  localparam int A_ACT_A = 3;
  localparam int A_ACT_B = 4;
  localparam int A_FRC   = 5;

  typedef enum logic [1:0] {
    AQ_KEEP = 2'd0, AQ_LOW = 2'd1, AQ_HIGH = 2'd2, AQ_FLIP = 2'd3
  } aq_code_e;

  typedef enum logic [1:0] {
    FR_NONE = 2'd0, FR_LOW = 2'd1, FR_HIGH = 2'd2, FR_SPARE = 2'd3
  } fr_code_e;

  typedef struct packed {
    logic cb_dn;
    logic cb_up;
    logic ca_dn;
    logic ca_up;
    logic at_prd;
    logic at_zero;
  } tb_evt_t;

  function automatic logic aq_apply(input aq_code_e c, input logic cur);
    case (c)
      AQ_LOW:  aq_apply = 1'b0;
      AQ_HIGH: aq_apply = 1'b1;
      AQ_FLIP: aq_apply = ~cur;
      default: aq_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  prd_sh,
  output logic [CNT_W-1:0]  cmpa_sh,
  output logic [CNT_W-1:0]  cmpb_sh,
  output logic [ACT_W-1:0]  act_a,
  output logic [ACT_W-1:0]  act_b,
  output logic [2*NCH-1:0]  frc_sh
);
  logic prd_en, ca_en, cb_en, aa_en, ab_en, fr_en;
  logic [CNT_W-1:0] prd_q, ca_q, cb_q;
  logic [ACT_W-1:0] aa_q, ab_q;
  logic [2*NCH-1:0] fr_q;

  always_comb begin
    prd_en = wr_en && (wr_addr == ADDR_W'(A_PRD));
    ca_en  = wr_en && (wr_addr == ADDR_W'(A_CMPA));
    cb_en  = wr_en && (wr_addr == ADDR_W'(A_CMPB));
    aa_en  = wr_en && (wr_addr == ADDR_W'(A_ACT_A));
    ab_en  = wr_en && (wr_addr == ADDR_W'(A_ACT_B));
    fr_en  = wr_en && (wr_addr == ADDR_W'(A_FRC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q <= '0;
      ca_q  <= '0;
      cb_q  <= '0;
      aa_q  <= '0;
      ab_q  <= '0;
      fr_q  <= '0;
    end else begin
      if (prd_en) prd_q <= wr_data[CNT_W-1:0];
      if (ca_en)  ca_q  <= wr_data[CNT_W-1:0];
      if (cb_en)  cb_q  <= wr_data[CNT_W-1:0];
      if (aa_en)  aa_q  <= wr_data[ACT_W-1:0];
      if (ab_en)  ab_q  <= wr_data[ACT_W-1:0];
      if (fr_en)  fr_q  <= wr_data[2*NCH-1:0];
    end
  end

  assign prd_sh  = prd_q;
  assign cmpa_sh = ca_q;
  assign cmpb_sh = cb_q;
  assign act_a   = aa_q;
  assign act_b   = ab_q;
  assign frc_sh  = fr_q;
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prd_sh,
  input  logic [CNT_W-1:0] cmpa_sh,
  input  logic [CNT_W-1:0] cmpb_sh,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cmpa_act,
  output logic             load,
  output logic             prd_pulse,
  output tb_evt_t          evt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d, prd_q, ca_q, cb_q;
  logic dir_q, dir_d, pulse_q, is_zero, hit_prd, hit_ca, hit_cb;

  always_comb begin
    is_zero = (cnt_q == ZERO);
    hit_prd = (prd_q != ZERO) && (cnt_q == prd_q);
    hit_ca  = (cnt_q == ca_q);
    hit_cb  = (cnt_q == cb_q);
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    if (is_zero) begin
      dir_d = 1'b1;
      cnt_d = (prd_sh != ZERO) ? ONE : ZERO;
    end else if (dir_q && (cnt_q < prd_q)) begin
      cnt_d = cnt_q + ONE;
    end else begin
      dir_d = 1'b0;
      cnt_d = cnt_q - ONE;
    end
  end

  always_comb begin
    evt.at_zero = is_zero;
    evt.at_prd  = hit_prd;
    evt.ca_up   = hit_ca && dir_q;
    evt.ca_dn   = hit_ca && !dir_q;
    evt.cb_up   = hit_cb && dir_q;
    evt.cb_dn   = hit_cb && !dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      pulse_q <= hit_prd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q <= '0;
      ca_q  <= '0;
      cb_q  <= '0;
    end else if (is_zero) begin
      prd_q <= prd_sh;
      ca_q  <= cmpa_sh;
      cb_q  <= cmpb_sh;
    end
  end

  assign cnt       = cnt_q;
  assign dir_up    = dir_q;
  assign prd_act   = prd_q;
  assign cmpa_act  = ca_q;
  assign load      = is_zero;
  assign prd_pulse = pulse_q;
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tb_evt_t          evt,
  input  logic [ACT_W-1:0] act,
  input  logic [1:0]       frc_sh,
  input  logic             load,
  output logic             pwm,
  output logic [1:0]       frc_act
);
  logic [1:0] frc_q, frc_d, code;
  logic out_q, out_d;

  always_comb begin
    frc_d = load ? frc_sh : frc_q;
    code  = 2'd0;
    if (evt.at_zero)                     code = act[1:0];
    if (evt.at_prd && act[3:2] != 2'd0)  code = act[3:2];
    if (evt.ca_up  && act[5:4] != 2'd0)  code = act[5:4];
    if (evt.ca_dn  && act[7:6] != 2'd0)  code = act[7:6];
    if (evt.cb_up  && act[9:8] != 2'd0)  code = act[9:8];
    if (evt.cb_dn  && act[11:10] != 2'd0) code = act[11:10];
    case (fr_code_e'(frc_d))
      FR_LOW:  out_d = 1'b0;
      FR_HIGH: out_d = 1'b1;
      default: out_d = aq_apply(aq_code_e'(code), out_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= 2'd0;
      out_q <= 1'b0;
    end else begin
      frc_q <= frc_d;
      out_q <= out_d;
    end
  end

  assign pwm     = out_q;
  assign frc_act = frc_q;
endmodule

// File: rtl/pwm_updown_aq.sv
module pwm_updown_aq
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              evt_prd_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_up_o
);
  logic rst_meta_q, rst_sync_n;
  logic [CNT_W-1:0] prd_sh_w, cmpa_sh_w, cmpb_sh_w, prd_act_w, cmpa_act_w;
  logic [ACT_W-1:0] act_a_w, act_b_w;
  logic [ACT_W-1:0] act_w [NCH];
  logic [2*NCH-1:0] frc_sh_w;
  logic [1:0] frc_act_w [NCH];
  logic [1:0] frc_act_a_w, frc_act_b_w;
  logic [NCH-1:0] pwm_w;
  logic load_w;
  tb_evt_t evt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pwm_aq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prd_sh(prd_sh_w), .cmpa_sh(cmpa_sh_w),
    .cmpb_sh(cmpb_sh_w), .act_a(act_a_w), .act_b(act_b_w), .frc_sh(frc_sh_w)
  );

  pwm_aq_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_sync_n), .prd_sh(prd_sh_w), .cmpa_sh(cmpa_sh_w),
    .cmpb_sh(cmpb_sh_w), .cnt(cnt_o), .dir_up(dir_up_o), .prd_act(prd_act_w),
    .cmpa_act(cmpa_act_w), .load(load_w), .prd_pulse(evt_prd_o), .evt(evt_w)
  );

  assign act_w[0] = act_a_w;
  assign act_w[1] = act_b_w;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_aq_chan ch_i (
      .clk(clk), .rst_n(rst_sync_n), .evt(evt_w), .act(act_w[g]),
      .frc_sh(frc_sh_w[2*g +: 2]), .load(load_w), .pwm(pwm_w[g]),
      .frc_act(frc_act_w[g])
    );
  end

  assign frc_act_a_w = frc_act_w[0];
  assign frc_act_b_w = frc_act_w[1];
  assign pwm_a_o     = pwm_w[0];
  assign pwm_b_o     = pwm_w[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_up,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] prd_sh,
  input logic [CNT_W-1:0] cmpa_act,
  input logic [1:0]       frc_a,
  input logic [1:0]       frc_b,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             evt
);
  // R1
  cnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && cnt != '0 && cnt < prd_act) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R1
  cnt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_up && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && prd_sh == '0) |=> (cnt == '0));
  // R3
  cmp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(cmpa_act));
  // R8
  frc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_a == 2'd1 && cnt != '0) |=> !pwm_a);
  // R8
  frc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_b == 2'd2 && cnt != '0) |=> pwm_b);
  // R9
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R9
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == prd_act && prd_act != '0) |=> evt);
endmodule

bind pwm_updown_aq pwm_aq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .cnt(cnt_o), .dir_up(dir_up_o),
  .prd_act(prd_act_w), .prd_sh(prd_sh_w), .cmpa_act(cmpa_act_w),
  .frc_a(frc_act_a_w), .frc_b(frc_act_b_w), .pwm_a(pwm_a_o),
  .pwm_b(pwm_b_o), .evt(evt_prd_o)
);

// File: tb/pwm_updown_aq_tb_top.sv
module pwm_updown_aq_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_a, pwm_b, evt, dir_up;
  logic [CW-1:0] cnt;

  always #5 clk = ~clk;

  pwm_updown_aq #(.CNT_W(CW), .DATA_W(16), .ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b),
    .evt_prd_o(evt), .cnt_o(cnt), .dir_up_o(dir_up)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R4";

  // behavioural reference state
  int m_cnt = 0, m_dir = 1, m_prd_a = 0, m_ca_a = 0, m_cb_a = 0;
  int m_prd_s = 0, m_ca_s = 0, m_cb_s = 0, m_evt = 0;
  int m_out [2] = '{0, 0};
  int m_frc_s [2] = '{0, 0};
  int m_frc_a [2] = '{0, 0};
  int m_act [2][6];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int zero, pe, code, fr, nxt;
    int n_out [2];
    zero = (m_cnt == 0);
    pe   = (m_prd_a != 0 && m_cnt == m_prd_a);
    for (int o = 0; o < 2; o++) begin
      code = 0;
      if (zero) code = m_act[o][0];
      if (pe && m_act[o][1] != 0) code = m_act[o][1];
      if (m_cnt == m_ca_a && m_act[o][m_dir ? 2 : 3] != 0) code = m_act[o][m_dir ? 2 : 3];
      if (m_cnt == m_cb_a && m_act[o][m_dir ? 4 : 5] != 0) code = m_act[o][m_dir ? 4 : 5];
      fr = zero ? m_frc_s[o] : m_frc_a[o];
      if (fr == 1) nxt = 0;
      else if (fr == 2) nxt = 1;
      else if (code == 1) nxt = 0;
      else if (code == 2) nxt = 1;
      else if (code == 3) nxt = 1 - m_out[o];
      else nxt = m_out[o];
      n_out[o] = nxt;
      if (zero) m_frc_a[o] = m_frc_s[o];
    end
    m_out = n_out;
    m_evt = pe;
    if (zero) begin
      m_dir = 1;
      m_cnt = (m_prd_s != 0) ? 1 : 0;
      m_prd_a = m_prd_s; m_ca_a = m_ca_s; m_cb_a = m_cb_s;
    end else if (m_dir == 1 && m_cnt < m_prd_a) begin
      m_cnt = m_cnt + 1;
    end else begin
      m_dir = 0;
      m_cnt = m_cnt - 1;
    end
    if (wr_en && rst_n) begin
      case (int'(wr_addr))
        0: m_prd_s = int'(wr_data);
        1: m_ca_s  = int'(wr_data);
        2: m_cb_s  = int'(wr_data);
        3, 4: for (int f = 0; f < 6; f++) m_act[int'(wr_addr) - 3][f] = (int'(wr_data) >> (2 * f)) & 3;
        5: begin m_frc_s[0] = int'(wr_data) & 3; m_frc_s[1] = (int'(wr_data) >> 2) & 3; end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    model_step();
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R1", "cnt", int'(cnt), m_cnt);
      check("R1", "dir_up", int'(dir_up), m_dir);
      check(cur_req, "pwm_a", int'(pwm_a), m_out[0]);
      check("R6", "pwm_b", int'(pwm_b), m_out[1]);
      check("R9", "evt", int'(evt), m_evt);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (int'(cnt) == v) return;
    end
    check("R1", "wait for counter value", int'(cnt), v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) for (int f = 0; f < 6; f++) m_act[i][f] = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R10 reset state
    check("R10", "cnt in reset", int'(cnt), 0);
    check("R10", "dir in reset", int'(dir_up), 1);
    check("R10", "pwm_a in reset", int'(pwm_a), 0);
    check("R10", "pwm_b in reset", int'(pwm_b), 0);
    check("R10", "evt in reset", int'(evt), 0);
    cmp_on = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);

    // R5 centred pulse: P=10, C=4, A high on rising, low on falling
    cur_req = "R5";
    wr(3, 16'h0060);
    wr(4, 16'h0102);   // R6 output B: high at zero, low on compare-B rising
    wr(1, 4);
    wr(2, 7);
    wr(0, 10);
    for (int i = 0; i < 45; i++) @(negedge clk);
    begin
      int hi = 0, pulses = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        hi += int'(pwm_a);
        pulses += int'(evt);
      end
      check("R5", "pwm_a high clocks in two cycles", hi, 24);
      check("R9", "period pulses in two cycles", pulses, 2);
    end

    // R3 staged values wait for zero
    cur_req = "R3";
    wait_cnt(3);
    wr(1, 8);
    wr(0, 6);
    wait_cnt(10);
    check("R3", "peak keeps old period", int'(cnt), 10);
    wait_cnt(6);
    wait_cnt(0);
    wait_cnt(6);
    @(negedge clk);
    check("R3", "new period turns at 6", int'(cnt), 5);

    // R4 toggle at zero
    cur_req = "R4";
    wr(3, 16'h0003);
    for (int i = 0; i < 40; i++) @(negedge clk);

    // R7 compare B beats compare A at the same count
    cur_req = "R7";
    wr(1, 3);
    wr(2, 3);
    wr(3, 16'h0120);
    wait_cnt(0);
    wait_cnt(0);
    @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        hi += int'(pwm_a);
      end
      check("R7", "pwm_a stays low under compare-B priority", hi, 0);
    end

    // R8 force A high, B low, taken at zero
    cur_req = "R8";
    wait_cnt(4);
    wr(5, 16'h0006);
    wait_cnt(0);
    @(negedge clk);
    check("R8", "forced pwm_a", int'(pwm_a), 1);
    check("R8", "forced pwm_b", int'(pwm_b), 0);
    for (int i = 0; i < 15; i++) @(negedge clk);
    check("R8", "pwm_a still forced", int'(pwm_a), 1);
    wr(5, 0);
    for (int i = 0; i < 30; i++) @(negedge clk);

    // R2 zero period freezes the counter
    cur_req = "R2";
    wr(0, 0);
    wait_cnt(0);
    begin
      int moved = 0, pulses = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (cnt != '0) moved++;
        pulses += int'(evt);
      end
      check("R2", "counter moves at zero period", moved, 0);
      check("R2", "pulses at zero period", pulses, 0);
    end

    // R9 period of one
    cur_req = "R9";
    wr(0, 1);
    for (int i = 0; i < 20; i++) @(negedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end
endmodule